// File: doc/BRIEF.md
# Shared Iterative Multiply/Divide Unit

A sequential arithmetic unit that either multiplies two 32-bit operands or divides one by the other, one bit per clock. Both operations share one double-width shift register and one single-width adder/subtractor. The multiplier, or the growing quotient, sits in the low half of that register. The partial product, or the partial remainder, sits in the high half. For signed work the operands are first reduced to magnitudes, and the signs are applied again in a closing cycle.

The caller pulses `start` with the operation, the signedness flag and both operands. The unit then runs for a fixed number of clocks and raises `done` for one cycle. A multiply returns its 64-bit product as `{result_hi, result_lo}`. A divide returns the quotient on `result_lo` and the remainder on `result_hi`.

Top module: `shared_muldiv`

## Requirements
- R1: While reset is held and after it is released, `busy` and `done` are 0 and `result_hi`/`result_lo` are all zeros.
- R2: With `op_div`=0 and `signed_mode`=0, the result `{result_hi,result_lo}` is the full unsigned 64-bit product `opa*opb`.
- R3: With `op_div`=0 and `signed_mode`=1, the result is the 64-bit two's-complement product of the operands read as signed numbers.
- R4: With `op_div`=1 and `signed_mode`=0 and `opb`≠0, `result_lo` is the unsigned quotient `opa/opb` and `result_hi` is the remainder `opa%opb`.
- R5: With `op_div`=1 and `signed_mode`=1 and `opb`≠0, the quotient is truncated toward zero. It is negative only when the operand signs differ. The remainder carries the sign of `opa`.
- R6: When `op_div`=1 and `opb`=0, in either mode, `result_lo` is all ones and `result_hi` equals `opa`.
- R7: `done` is high for exactly one cycle. It is first seen after the 34th rising edge, counting the edge that samples `start` as the first (W+2 edges). `busy` is high from the edge after acceptance until `done` rises, and it is low while `done` is high.
- R8: While `busy` is high, `start` pulses and changes on `op_div`, `signed_mode`, `opa` and `opb` have no effect on the result of the operation in progress.
- R9: `result_hi` and `result_lo` only change in the cycle in which `done` rises. They hold their value until the next operation completes.
- R10: A signed divide of 0x80000000 by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins an operation when the unit is idle |
| op_div | input | 1 | 1 selects divide, 0 selects multiply |
| signed_mode | input | 1 | 1 treats operands as two's complement |
| opa | input | 32 | Multiplicand or dividend |
| opb | input | 32 | Multiplier or divisor |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion strobe |
| result_hi | output | 32 | Product upper half, or remainder |
| result_lo | output | 32 | Product lower half, or quotient |

## Verification
The checker assumes a `start` is only honoured while `busy` is low. It captures the operands on that cycle and compares them against the completed result. It also assumes reset is applied from time zero, so that the result-hold property has a defined earlier value. The stimulus keeps to this in two ways: operands are driven on the falling edge, and the one deliberate `start` issued while busy is there to show that it is discarded, not to launch a second run.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [1:0] {
        MD_IDLE = 2'd0,
        MD_STEP = 2'd1,
        MD_FIX  = 2'd2
    } md_state_e;

endpackage

// File: rtl/md_addsub.sv
module md_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W-1:0] b_eff;

    always_comb begin
        b_eff       = sub ? ~b : b;
        {cout, sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    end
endmodule

// File: rtl/md_negate.sv
module md_negate #(
    parameter int W = 32
) (
    input  logic         en,
    input  logic [W-1:0] val,
    output logic [W-1:0] res
);
    always_comb res = en ? (~val + {{(W-1){1'b0}}, 1'b1}) : val;
endmodule

// File: rtl/shared_muldiv.sv
module shared_muldiv
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         op_div,
    input  logic         signed_mode,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result_hi,
    output logic [W-1:0] result_lo
);
    localparam int DW = 2 * W;
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

    typedef struct packed {
        md_state_e       st;
        logic [CW-1:0]   cnt;
        logic [DW-1:0]   acc;     // high: partial product/remainder, low: multiplier/quotient
        logic [W-1:0]    opd;     // multiplicand or divisor magnitude
        logic            is_div;
        logic            neg_lo;  // negate product or quotient
        logic            neg_hi;  // negate remainder
        logic [DW-1:0]   res;
        logic            done;
    } md_regs_t;

    md_regs_t q, d;

    // operand magnitudes
    logic          sgn_a, sgn_b;
    logic [W-1:0]  mag_a, mag_b;

    assign sgn_a = signed_mode & opa[W-1];
    assign sgn_b = signed_mode & opb[W-1];

    md_negate #(.W(W)) u_abs_a (.en(sgn_a), .val(opa), .res(mag_a));
    md_negate #(.W(W)) u_abs_b (.en(sgn_b), .val(opb), .res(mag_b));

    // shared add/subtract path
    logic [W-1:0]  acc_hi, acc_lo, sh_hi;
    logic [W-1:0]  as_a, as_sum;
    logic          as_cout;

    assign acc_hi = q.acc[DW-1:W];
    assign acc_lo = q.acc[W-1:0];
    assign sh_hi  = q.acc[DW-2:W-1];
    assign as_a   = q.is_div ? sh_hi : acc_hi;

    md_addsub #(.W(W)) u_addsub (
        .a   (as_a),
        .b   (q.opd),
        .sub (q.is_div),
        .sum (as_sum),
        .cout(as_cout)
    );

    // sign restoration
    logic [DW-1:0] prod_fix;
    logic [W-1:0]  quot_fix, rem_fix;

    md_negate #(.W(DW)) u_fix_prod (.en(q.neg_lo), .val(q.acc),  .res(prod_fix));
    md_negate #(.W(W))  u_fix_quot (.en(q.neg_lo), .val(acc_lo), .res(quot_fix));
    md_negate #(.W(W))  u_fix_rem  (.en(q.neg_hi), .val(acc_hi), .res(rem_fix));

    logic fits;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        fits   = q.acc[DW-1] | as_cout;
        case (q.st)
            MD_IDLE: begin
                if (start) begin
                    d.st     = MD_STEP;
                    d.cnt    = '0;
                    d.is_div = op_div;
                    if (op_div) begin
                        d.acc    = {{W{1'b0}}, mag_a};
                        d.opd    = mag_b;
                        d.neg_lo = (sgn_a ^ sgn_b) & (opb != '0);
                        d.neg_hi = sgn_a;
                    end else begin
                        d.acc    = {{W{1'b0}}, mag_b};
                        d.opd    = mag_a;
                        d.neg_lo = sgn_a ^ sgn_b;
                        d.neg_hi = 1'b0;
                    end
                end
            end
            MD_STEP: begin
                if (q.is_div) begin
                    d.acc = {(fits ? as_sum : sh_hi), acc_lo[W-2:0], fits};
                end else if (q.acc[0]) begin
                    d.acc = {as_cout, as_sum, acc_lo[W-1:1]};
                end else begin
                    d.acc = {1'b0, q.acc[DW-1:1]};
                end
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == LAST_STEP) d.st = MD_FIX;
            end
            MD_FIX: begin
                d.res  = q.is_div ? {rem_fix, quot_fix} : prod_fix;
                d.done = 1'b1;
                d.st   = MD_IDLE;
            end
            default: d.st = MD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy      = (q.st != MD_IDLE);
    assign done      = q.done;
    assign result_hi = q.res[DW-1:W];
    assign result_lo = q.res[W-1:0];
endmodule

// File: rtl/md_check.sv
module md_check #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         op_div,
    input logic         signed_mode,
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] result_hi,
    input logic [W-1:0] result_lo
);
    localparam int LW = $clog2(W) + 3;

    logic [W-1:0]  cap_a, cap_b;
    logic          cap_div, cap_sgn;
    logic [LW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_a   <= '0;
            cap_b   <= '0;
            cap_div <= 1'b0;
            cap_sgn <= 1'b0;
            run_len <= '0;
        end else begin
            if (start && !busy) begin
                cap_a   <= opa;
                cap_b   <= opb;
                cap_div <= op_div;
                cap_sgn <= signed_mode;
            end
            if (!busy) run_len <= '0;
            else       run_len <= run_len + 1'b1;
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7
    run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len == LW'(W + 1)));

    // R2
    unsigned_product_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cap_div && !cap_sgn) |->
            ({result_hi, result_lo} == ({{W{1'b0}}, cap_a} * {{W{1'b0}}, cap_b})));

    // R6
    zero_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_div && (cap_b == '0)) |->
            ((result_lo == {W{1'b1}}) && (result_hi == cap_a)));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({result_hi, result_lo}));
endmodule

bind shared_muldiv md_check #(.W(W)) u_md_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .op_div     (op_div),
    .signed_mode(signed_mode),
    .opa        (opa),
    .opb        (opb),
    .busy       (busy),
    .done       (done),
    .result_hi  (result_hi),
    .result_lo  (result_lo)
);

// File: tb/shared_muldiv_test.sv
`timescale 1ns/1ps
module shared_muldiv_test;
    localparam int W   = 32;
    localparam int LAT = W + 2;
    localparam int NV  = 18;

    logic          clk = 1'b0;
    logic          rst_n, start, op_div, signed_mode;
    logic [W-1:0]  opa, opb, result_hi, result_lo;
    logic          busy, done;
    int            checks = 0;
    int            errors = 0;

    always #2 clk = ~clk;

    shared_muldiv #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
        .signed_mode(signed_mode), .opa(opa), .opb(opb), .busy(busy),
        .done(done), .result_hi(result_hi), .result_lo(result_lo)
    );

    // {op_div, signed_mode, opa, opb}
    localparam logic [65:0] VEC [NV] = '{
        {1'b0, 1'b0, 32'h0000_0003, 32'h0000_0005},
        {1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {1'b0, 1'b0, 32'h1234_5678, 32'h9ABC_DEF0},
        {1'b0, 1'b0, 32'h0000_0000, 32'hDEAD_BEEF},
        {1'b0, 1'b1, 32'hFFFF_FFFD, 32'h0000_0007},
        {1'b0, 1'b1, 32'h8000_0000, 32'h8000_0000},
        {1'b0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {1'b0, 1'b1, 32'h7FFF_FFFF, 32'h8000_0000},
        {1'b1, 1'b0, 32'h0000_0064, 32'h0000_0007},
        {1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0000_0003},
        {1'b1, 1'b0, 32'h0000_0005, 32'h0000_0009},
        {1'b1, 1'b0, 32'hDEAD_BEEF, 32'h8000_0001},
        {1'b1, 1'b1, 32'hFFFF_FF9C, 32'h0000_0007},
        {1'b1, 1'b1, 32'h0000_0064, 32'hFFFF_FFF9},
        {1'b1, 1'b1, 32'hFFFF_FF9C, 32'hFFFF_FFF9},
        {1'b1, 1'b1, 32'h8000_0000, 32'hFFFF_FFFF},
        {1'b1, 1'b0, 32'h0000_1234, 32'h0000_0000},
        {1'b1, 1'b1, 32'hFFFF_FFF0, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input logic dv, input logic sg,
                                          input logic [31:0] a, input logic [31:0] b);
        logic signed [63:0] sp;
        logic signed [31:0] sa, sb;
        sa = a;
        sb = b;
        if (!dv) begin
            if (sg) begin
                sp = 64'(sa) * 64'(sb);
                return sp;
            end
            return {32'h0, a} * {32'h0, b};
        end
        if (b == 32'h0) return {a, 32'hFFFF_FFFF};
        if (sg) begin
            if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return {32'h0, 32'h8000_0000};
            return {32'(sa % sb), 32'(sa / sb)};
        end
        return {a % b, a / b};
    endfunction

    function automatic string tag(input logic dv, input logic sg,
                                  input logic [31:0] a, input logic [31:0] b);
        if (!dv) return sg ? "R3" : "R2";
        if (b == 32'h0) return "R6";
        if (sg && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return "R10";
        return sg ? "R5" : "R4";
    endfunction

    task automatic run_op(input logic dv, input logic sg, input logic [31:0] a,
                          input logic [31:0] b, output logic [63:0] res, output int lat);
        @(negedge clk);
        op_div = dv; signed_mode = sg; opa = a; opb = b; start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        lat = 1;
        while (!done && lat < 200) begin
            @(posedge clk);
            #1 lat++;
        end
        res = {result_hi, result_lo};
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL R7 watchdog actual no-finish expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] res, keep;
        int          lat;
        rst_n = 1'b0; start = 1'b0; op_div = 1'b0; signed_mode = 1'b0;
        opa = '0; opb = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1 during reset
        check("R1", {62'h0, busy, done}, 64'h0);
        check("R1", {result_hi, result_lo}, 64'h0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", {62'h0, busy, done}, 64'h0);

        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i][65], VEC[i][64], VEC[i][63:32], VEC[i][31:0], res, lat);
            check(tag(VEC[i][65], VEC[i][64], VEC[i][63:32], VEC[i][31:0]), res,
                  model(VEC[i][65], VEC[i][64], VEC[i][63:32], VEC[i][31:0]));
            if (i == 0 || i == 8) begin
                // R7 latency and single-cycle strobe
                check("R7", 64'(lat), 64'(LAT));
                @(posedge clk);
                #1 check("R7", {63'h0, done}, 64'h0);
            end
        end

        // R8: a second start and new operands while busy are discarded
        @(negedge clk);
        op_div = 1'b0; signed_mode = 1'b0; opa = 32'h10; opb = 32'h20; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        op_div = 1'b1; signed_mode = 1'b1; opa = 32'h7; opb = 32'h3; start = 1'b1;
        @(negedge clk);
        start = 1'b0; opa = 32'hFFFF_0000;
        while (!done) @(negedge clk);
        check("R8", {result_hi, result_lo}, 64'h200);
        keep = {result_hi, result_lo};

        // R9: outputs hold after completion with inputs moving and no start
        repeat (10) begin
            @(negedge clk);
            opa = opa + 32'h11; opb = opb ^ 32'h5A5A;
        end
        check("R9", {result_hi, result_lo}, keep);
        check("R8", {63'h0, busy}, 64'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule